// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder

This block turns a serial message into a systematic codeword for a quasi-cyclic low-density parity-check code. The parity-check matrix is a row of `L` square circulant blocks, each `M` by `M`. The first circulant is invertible. Each remaining message block of `M` bits therefore maps onto the `M` parity bits through one circulant generator block. Only the first row of each generator block is held, as a parameter. A rotating register walks that row through its cyclic shifts, one position for each message bit. Every message bit equal to one XORs the current shifted row into a parity accumulator. The generator rows are worked out offline from the parity-check circulants and passed in as parameters.

A run begins with a one-cycle `start` pulse. The block then raises `in_ready` and takes `(L-1)*M` message bits over a valid/ready handshake. One cycle after the last bit it pulses `done`. The parallel codeword on `cw_out` then holds until the next `start`. With the defaults (`M` = 15, `L` = 2) a 15-bit message becomes a 30-bit codeword at rate one half.

Top module: `qc_ldpc_encoder`

## Requirements
- R1: While reset is held and after it is released, `in_ready` and `done` are 0 and `cw_out` is all zeros.
- R2: In the cycle after a `start` pulse, `cw_out` is all zeros and `in_ready` is 1.
- R3: A message bit is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` stays 1 until exactly `(L-1)*M` bits have been taken, and is 0 from then until the next `start`.
- R4: Codeword layout: for k < `(L-1)*M`, `cw_out[k]` is the k-th message bit taken, counting from 0. `cw_out[(L-1)*M + k]` is parity bit k.
- R5: Treat message block b (bits b*M to b*M+M-1) as a polynomial u_b(x) whose bit j is the coefficient of x^j. Treat slice b of `GEN_ROWS` the same way as q_b(x). The parity polynomial is then the XOR over b of q_b(x)·u_b(x) mod (x^M − 1). Equivalently, each accepted one at position j of block b XORs q_b, rotated toward higher indices by j (bit k moves to (k+j) mod M), into the parity.
- R6: Every codeword has a zero syndrome under the parity-check matrix [H1 H2 … HL]. Here H1 is the circulant of 1 + x^5 + x^9 and H(b+2) is the circulant of h1(x)·q_b(x) mod (x^M − 1). For every one of the M rows, the XOR of h1·p and all h(b+2)·u_b is 0.
- R7: `done` is 1 for exactly one cycle: the cycle after the edge on which the last message bit is taken. `cw_out` keeps its value until the next `start`.
- R8: Cycles with `in_valid` low leave the run unchanged, whatever `in_bit` carries. This holds inside a run and while idle.
- R9: A `start` pulse in the middle of a message takes priority over a bit offered in the same cycle. That bit is dropped, the partial codeword is discarded, and the next `(L-1)*M` bits form a fresh message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new codeword |
| in_valid | input | 1 | Message bit on `in_bit` is offered |
| in_bit | input | 1 | Serial message bit |
| in_ready | output | 1 | Block accepts a message bit this cycle |
| cw_out | output | L*M | Codeword: message bits in the low part, parity in the high part |
| done | output | 1 | One-cycle pulse: codeword on `cw_out` is complete |

## Verification
Two functions of the block can fall in the same cycle: a new `start` and the acceptance of a message bit. The bench provokes the overlap by raising `start` together with a valid one-bit partway through a message, on a block that is busy. It then feeds a complete second message. The result is judged correct only if the codeword, its parity and its syndrome match the second message alone, and `cw_out` reads all zeros right after the collision. A second overlap is also exercised: the edge that takes the last bit of a block must both XOR the current row and load the next state. This is covered by every run, and parity is compared against a polynomial product computed in the bench.

// File: rtl/qc_enc_pkg.sv
package qc_enc_pkg;

    // Default code geometry: circulant size and number of circulant blocks
    localparam int DEF_M = 15;
    localparam int DEF_L = 2;

    // Parity-check first circulant h1(x) = 1 + x^5 + x^9
    localparam logic [DEF_M-1:0] DEF_H1 = 15'h0221;

    // Generator circulant first row q(x) = 1 + x^3 + x^4 + x^8 + x^11
    localparam logic [(DEF_L-1)*DEF_M-1:0] DEF_GEN = 15'h0919;

    typedef enum logic {
        ENC_IDLE = 1'b0,
        ENC_RUN  = 1'b1
    } enc_phase_e;

    // Safe width for a counter that must hold values 0..n-1
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qc_enc_ctrl.sv
module qc_enc_ctrl
    import qc_enc_pkg::*;
#(
    parameter int M = DEF_M,
    parameter int NB = DEF_L - 1,
    localparam int CNT_W = cnt_width(M),
    localparam int BLK_W = cnt_width(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             step,
    output logic             row_load,
    output logic [BLK_W-1:0] row_sel,
    output logic             row_shift,
    output logic             done
);

    typedef struct packed {
        enc_phase_e       phase;
        logic [BLK_W-1:0] blk;
        logic [CNT_W-1:0] pos;
        logic             done;
    } ctrl_state_t;

    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(M - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NB - 1);

    ctrl_state_t st_q, st_d;
    logic        pos_end;
    logic        blk_end;

    assign in_ready = (st_q.phase == ENC_RUN);
    assign step     = in_ready && in_valid && !start;
    assign pos_end  = (st_q.pos == POS_LAST);
    assign blk_end  = (st_q.blk == BLK_LAST);
    assign done     = st_q.done;

    // Row register: load block 0 on start, next block at a block boundary
    assign row_load  = start || (step && pos_end && !blk_end);
    assign row_sel   = start ? '0 : st_q.blk + 1'b1;
    assign row_shift = step && !pos_end;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.phase = ENC_RUN;
            st_d.blk   = '0;
            st_d.pos   = '0;
        end else if (step) begin
            if (pos_end) begin
                st_d.pos = '0;
                if (blk_end) begin
                    st_d.phase = ENC_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.blk = st_q.blk + 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: ENC_IDLE, blk: '0, pos: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/qc_row_rotator.sv
module qc_row_rotator
    import qc_enc_pkg::*;
#(
    parameter int M = DEF_M,
    parameter int NB = DEF_L - 1,
    parameter logic [NB*M-1:0] GEN_ROWS = DEF_GEN,
    localparam int BLK_W = cnt_width(NB),
    localparam int NSLOT = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BLK_W-1:0] sel,
    input  logic             shift,
    output logic [M-1:0]     row
);

    logic [M-1:0] slot_rows [NSLOT];

    // Unused slots (when NB is not a power of two) read as zero
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s < NB) begin : g_used
            assign slot_rows[s] = GEN_ROWS[s*M +: M];
        end else begin : g_pad
            assign slot_rows[s] = '0;
        end
    end

    logic [M-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (load) begin
            row_q <= slot_rows[sel];
        end else if (shift) begin
            // bit k moves to k+1; top bit wraps to 0
            row_q <= {row_q[M-2:0], row_q[M-1]};
        end
    end

    assign row = row_q;

endmodule

// File: rtl/qc_parity_acc.sv
module qc_parity_acc
    import qc_enc_pkg::*;
#(
    parameter int M = DEF_M
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic         bit_in,
    input  logic [M-1:0] row,
    output logic [M-1:0] parity
);

    logic [M-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (step && bit_in) begin
            acc_q <= acc_q ^ row;
        end
    end

    assign parity = acc_q;

endmodule

// File: rtl/qc_msg_store.sv
module qc_msg_store
    import qc_enc_pkg::*;
#(
    parameter int MB = (DEF_L - 1) * DEF_M
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic          bit_in,
    output logic [MB-1:0] msg
);

    logic [MB-1:0] msg_q;

    // Shift toward index 0 so the first bit taken lands at index 0
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            msg_q <= '0;
        end else if (step) begin
            if (MB > 1) begin
                msg_q <= {bit_in, msg_q[MB-1:1]};
            end else begin
                msg_q <= MB'(bit_in);
            end
        end
    end

    assign msg = msg_q;

endmodule

// File: rtl/qc_ldpc_encoder.sv
module qc_ldpc_encoder
    import qc_enc_pkg::*;
#(
    parameter int M = DEF_M,
    parameter int L = DEF_L,
    parameter logic [(L-1)*M-1:0] GEN_ROWS = DEF_GEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         in_valid,
    input  logic         in_bit,
    output logic         in_ready,
    output logic [L*M-1:0] cw_out,
    output logic         done
);

    localparam int NB    = L - 1;
    localparam int MB    = NB * M;
    localparam int BLK_W = cnt_width(NB);

    logic             step;
    logic             row_load;
    logic [BLK_W-1:0] row_sel;
    logic             row_shift;
    logic [M-1:0]     row;
    logic [M-1:0]     parity;
    logic [MB-1:0]    msg;

    qc_enc_ctrl #(.M(M), .NB(NB)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .step      (step),
        .row_load  (row_load),
        .row_sel   (row_sel),
        .row_shift (row_shift),
        .done      (done)
    );

    qc_row_rotator #(.M(M), .NB(NB), .GEN_ROWS(GEN_ROWS)) rot_i (
        .clk   (clk),
        .rst   (rst),
        .load  (row_load),
        .sel   (row_sel),
        .shift (row_shift),
        .row   (row)
    );

    qc_parity_acc #(.M(M)) acc_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .step   (step),
        .bit_in (in_bit),
        .row    (row),
        .parity (parity)
    );

    qc_msg_store #(.MB(MB)) msg_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .step   (step),
        .bit_in (in_bit),
        .msg    (msg)
    );

    assign cw_out = {parity, msg};

endmodule

// File: rtl/qc_ldpc_encoder_chk.sv
module qc_ldpc_encoder_chk #(
    parameter int M = 15,
    parameter int L = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           in_valid,
    input logic           in_ready,
    input logic [L*M-1:0] cw_out,
    input logic           done
);

    // R2: start empties the codeword
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (cw_out == '0));

    // R2: a run opens only after start
    assert_ready_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(start));

    // R3: a gap in valid does not end a run
    assert_gap_keeps_run_R3: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid && !start) |=> in_ready);

    // R7: done lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: no bits are taken once the codeword is complete
    assert_done_closes_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R7: idle codeword holds until the next start
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !start) |=> $stable(cw_out));

endmodule

bind qc_ldpc_encoder qc_ldpc_encoder_chk #(.M(M), .L(L)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .cw_out   (cw_out),
    .done     (done)
);

// File: tb/qc_ldpc_encoder_tb_top.sv
module qc_ldpc_encoder_tb_top;
    import qc_enc_pkg::*;

    localparam int M  = DEF_M;
    localparam int L  = DEF_L;
    localparam int NB = L - 1;
    localparam int MB = NB * M;
    localparam int CW = L * M;
    localparam logic [MB-1:0] GEN = DEF_GEN;
    localparam logic [M-1:0]  H1  = DEF_H1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic          in_ready;
    logic [CW-1:0] cw_out;
    logic          done;

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    qc_ldpc_encoder #(.M(M), .L(L), .GEN_ROWS(GEN)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .in_ready (in_ready),
        .cw_out   (cw_out),
        .done     (done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Polynomial product modulo x^M - 1 over GF(2)
    function automatic logic [M-1:0] mulmod(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++)
                if (a[i] && b[j]) r[(i + j) % M] ^= 1'b1;
        return r;
    endfunction

    function automatic logic [M-1:0] exp_parity(input logic [MB-1:0] msg);
        logic [M-1:0] p = '0;
        for (int b = 0; b < NB; b++)
            p ^= mulmod(GEN[b*M +: M], msg[b*M +: M]);
        return p;
    endfunction

    function automatic logic [M-1:0] syndrome(input logic [CW-1:0] cw);
        logic [M-1:0] s;
        s = mulmod(H1, cw[MB +: M]);
        for (int b = 0; b < NB; b++)
            s ^= mulmod(mulmod(H1, GEN[b*M +: M]), cw[b*M +: M]);
        return s;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready == 1'b1 && cw_out == '0, "R2 start clears/ready",
              {cw_out[CW-1:1], in_ready}, CW'(1));
    endtask

    // Feed msg; gaps[k] inserts an idle cycle carrying a junk bit before bit k
    task automatic feed(input logic [MB-1:0] msg, input logic [MB-1:0] gaps);
        bit ready_ok = 1'b1;
        logic [CW-1:0] exp_cw;
        for (int k = 0; k < MB; k++) begin
            if (gaps[k]) begin
                in_valid = 1'b0;
                in_bit   = ~msg[k];
                @(negedge clk);
            end
            if (!in_ready || done) ready_ok = 1'b0;
            in_valid = 1'b1;
            in_bit   = msg[k];
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_bit   = 1'b1;
        exp_cw = {exp_parity(msg), msg};
        check(ready_ok, "R3 ready held during message", CW'(ready_ok), CW'(1));
        check(done == 1'b1 && in_ready == 1'b0, "R7/R3 done pulse, ready low",
              CW'({done, in_ready}), CW'(2'b10));
        check(cw_out[MB-1:0] == msg, "R4 message part", cw_out, exp_cw);
        check(cw_out[MB +: M] == exp_parity(msg), "R5 parity (R8 gaps)", cw_out, exp_cw);
        check(syndrome(cw_out) == '0, "R6 zero syndrome", CW'(syndrome(cw_out)), '0);
        @(negedge clk);
        check(done == 1'b0 && cw_out == exp_cw && in_ready == 1'b0,
              "R7 done single cycle, codeword held", cw_out, exp_cw);
    endtask

    task automatic encode(input logic [MB-1:0] msg, input logic [MB-1:0] gaps);
        pulse_start();
        feed(msg, gaps);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        logic [MB-1:0] msg, gaps;
        logic [CW-1:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0 && done == 1'b0 && cw_out == '0, "R1 during reset",
              cw_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0 && done == 1'b0 && cw_out == '0, "R1 after reset",
              cw_out, '0);

        // R8: valid bits while idle are ignored
        in_valid = 1'b1;
        in_bit   = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0 && cw_out == '0 && done == 1'b0, "R8 idle input ignored",
              cw_out, '0);

        // Corner patterns
        encode('0, '0);
        encode('1, '0);

        // All single-bit messages (R5 exercises each rotation)
        for (int i = 0; i < MB; i++) encode(MB'(1) << i, '0);

        // All two-bit messages
        for (int i = 0; i < MB; i++)
            for (int j = i + 1; j < MB; j++)
                encode((MB'(1) << i) | (MB'(1) << j), '0);

        // Pseudo-random messages with random valid gaps (R8)
        for (int n = 0; n < 120; n++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            msg  = lfsr[MB-1:0];
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            gaps = (n % 2 == 0) ? lfsr[MB-1:0] : '0;
            encode(msg, gaps);
        end

        // R7: codeword held for many idle cycles with junk inputs
        held = cw_out;
        in_bit = 1'b1;
        repeat (6) @(negedge clk);
        in_bit = 1'b0;
        check(cw_out == held && done == 1'b0, "R7 idle hold", cw_out, held);

        // R9: start collides with an accepted bit mid-message
        for (int cut = 1; cut < MB; cut += 4) begin
            pulse_start();
            for (int k = 0; k < cut; k++) begin
                in_valid = 1'b1;
                in_bit   = 1'b1;
                @(negedge clk);
            end
            start    = 1'b1;
            in_valid = 1'b1;
            in_bit   = 1'b1;
            @(negedge clk);
            start    = 1'b0;
            in_valid = 1'b0;
            check(cw_out == '0 && in_ready == 1'b1 && done == 1'b0,
                  "R9 restart drops colliding bit", cw_out, '0);
            msg = MB'(16'h2A5C + cut * 7);
            feed(msg, '0);
        end

        // R9: start in the same cycle as done begins a new run
        pulse_start();
        for (int k = 0; k < MB; k++) begin
            in_valid = 1'b1;
            in_bit   = k[0];
            @(negedge clk);
        end
        in_valid = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cw_out == '0 && in_ready == 1'b1, "R9 start on done cycle", cw_out, '0);
        feed(MB'(16'h0F0F), '0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule